// File: doc/BRIEF.md
# Binary64 Rounding and Packing Stage

This stage sits at the end of a double-precision arithmetic pipeline. An adder, subtractor, multiplier or divider hands it an unrounded result: a sign bit, a widened 12-bit biased exponent and a 56-bit mantissa word. The mantissa word holds, from the top down, one spare zero bit, the hidden bit, 52 fraction bits and two remainder bits (guard in bit 1, sticky in bit 0). A 2-bit mode picks one of four rounding directions.

The stage decides whether to add one unit in the last place (a one at mantissa bit 2), applies it, and renormalizes when the increment ripples into the spare top bit by shifting right one place and bumping the exponent. Since the exponent keeps a twelfth bit, a result that reaches or passes the all-ones 11-bit exponent is flagged as overflow instead of wrapping. The two remainder bits travel alongside so that a later exception stage can raise inexact. The packed 64-bit word, the overflow flag and the remainder bits are registered, with a valid one cycle after the input valid.

Top module: `fp64_round_unit`

## Requirements
- R1: While and right after synchronous reset, out_valid, out_word, out_ovf and out_rem are all zero.
- R2: out_valid equals in_valid delayed by one clock; when in_valid is low, out_word, out_ovf and out_rem keep their previous values.
- R3: Mode 2'b01 (toward zero) never increments: the output fraction equals in_mant[53:2].
- R4: Mode 2'b00 (nearest, ties to even) increments exactly when in_mant[1] is 1 and at least one of in_mant[0] or in_mant[2] is 1.
- R5: Mode 2'b10 (toward plus infinity) increments exactly when in_mant[1:0] is nonzero and in_sign is 0.
- R6: Mode 2'b11 (toward minus infinity) increments exactly when in_mant[1:0] is nonzero and in_sign is 1.
- R7: When the increment carries into mantissa bit 55, the fraction is taken one place further up (it becomes zero for a normalized all-ones input) and the exponent rises by one.
- R8: out_ovf is 1 exactly when the final 12-bit exponent (input exponent plus any renormalization carry) is 2047 or more.
- R9: out_word is packed as sign in bit 63, the low 11 bits of the final exponent in bits 62:52 and the rounded fraction in bits 51:0.
- R10: out_rem equals in_mant[1:0] of the accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result is present this cycle |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | 12 | Biased exponent with one guard bit on top |
| in_mant | input | 56 | Spare zero, hidden bit, 52 fraction bits, guard, sticky |
| in_mode | input | 2 | Rounding direction (00 nearest-even, 01 zero, 10 up, 11 down) |
| out_valid | output | 1 | Registered result is valid |
| out_word | output | 64 | Packed binary64 result |
| out_ovf | output | 1 | Final exponent reached 2047 or more |
| out_rem | output | 2 | Remainder bits of the accepted input |

## Verification
The increment carrying out of the mantissa and the overflow test act in the same cycle: a result whose fraction is all ones with exponent 2046 rounds up, renormalizes to exponent 2047 and must raise overflow at once. The sweep provokes this with all-ones fractions crossed with exponents 2046 and 2047 under every mode, sign and remainder pair, and judges the packed word and the flag against a bench model that adds the unit in integer arithmetic and derives the carry from the sum.

// File: rtl/fp64_rnd_pkg.sv
package fp64_rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TRUNC     = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import fp64_rnd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rnd_mode_e mode,
  input  logic      sign,
  input  logic      lsb,
  input  logic      guard,
  input  logic      sticky,
  output logic      bump
);
  logic any_rem;
  assign any_rem = guard | sticky;

  always_comb begin
    unique case (mode)
      RM_NEAR_EVEN: bump = guard & (sticky | lsb);
      RM_TRUNC:     bump = 1'b0;
      RM_UP:        bump = any_rem & ~sign;
      RM_DOWN:      bump = any_rem & sign;
      default:      bump = 1'b0;
    endcase
  end

  // R3: toward-zero mode never adds a unit
  a_r3_no_bump: assert property (@(posedge clk) disable iff (rst)
    (mode == RM_TRUNC) |-> !bump);
  // R5, R6: a directed increment needs a nonzero remainder and the matching sign
  a_r5_up_sign: assert property (@(posedge clk) disable iff (rst)
    (bump && mode == RM_UP) |-> (!sign && (guard || sticky)));
  a_r6_down_sign: assert property (@(posedge clk) disable iff (rst)
    (bump && mode == RM_DOWN) |-> (sign && (guard || sticky)));
  // R4: nearest-even never increments without the guard bit
  a_r4_guard: assert property (@(posedge clk) disable iff (rst)
    (bump && mode == RM_NEAR_EVEN) |-> guard);
endmodule

// File: rtl/rnd_apply.sv
module rnd_apply #(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W+3:0] in_mant,
  input  logic              bump,
  output logic [FRAC_W-1:0] frac_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              ovf_o
);
  localparam int MW = FRAC_W + 4;
  localparam logic [MW-1:0]    ULP  = MW'(4);
  localparam logic [EXP_W-1:0] EMAX = EXP_W'((1 << (EXP_W - 1)) - 1);

  logic [MW-1:0] sum;
  logic          carry;

  assign sum    = in_mant + (bump ? ULP : '0);
  assign carry  = sum[MW-1];
  assign frac_o = carry ? sum[MW-2:3] : sum[MW-3:2];
  assign exp_o  = in_exp + {{(EXP_W-1){1'b0}}, carry};
  assign ovf_o  = (exp_o >= EMAX);

  // R7: a carry born from the increment leaves an all-zero fraction
  a_r7_carry_zero: assert property (@(posedge clk) disable iff (rst)
    (carry && !in_mant[MW-1]) |-> (frac_o == '0));
  // R7: without an increment the exponent passes through untouched
  a_r7_no_bump_exp: assert property (@(posedge clk) disable iff (rst)
    (!bump && !in_mant[MW-1]) |-> (exp_o == in_exp));
endmodule

// File: rtl/fp64_round_unit.sv
module fp64_round_unit
  import fp64_rnd_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_sign,
  input  logic [EXP_W-1:0]            in_exp,
  input  logic [FRAC_W+3:0]           in_mant,
  input  logic [1:0]                  in_mode,
  output logic                        out_valid,
  output logic [FRAC_W+EXP_W-1:0]     out_word,
  output logic                        out_ovf,
  output logic [1:0]                  out_rem
);
  localparam int WORD_W = FRAC_W + EXP_W;

  logic              bump;
  logic [FRAC_W-1:0] frac_n;
  logic [EXP_W-1:0]  exp_n;
  logic              ovf_n;
  rnd_mode_e         mode;

  assign mode = rnd_mode_e'(in_mode);

  rnd_decide u_decide (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .sign   (in_sign),
    .lsb    (in_mant[2]),
    .guard  (in_mant[1]),
    .sticky (in_mant[0]),
    .bump   (bump)
  );

  rnd_apply #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_apply (
    .clk    (clk),
    .rst    (rst),
    .in_exp (in_exp),
    .in_mant(in_mant),
    .bump   (bump),
    .frac_o (frac_n),
    .exp_o  (exp_n),
    .ovf_o  (ovf_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_rem   <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= {in_sign, exp_n[EXP_W-2:0], frac_n};
        out_ovf  <= ovf_n;
        out_rem  <= in_mant[1:0];
      end
    end
  end

  // R2: valid is the input valid one cycle later
  a_r2_valid_on: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_off: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2: idle cycles leave the result alone
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(out_ovf) && $stable(out_rem)));
  // R3, R9: toward-zero copies the fraction field straight across
  a_r3_trunc_copy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'b01 && !in_mant[FRAC_W+3]) |=>
      (out_word[FRAC_W-1:0] == $past(in_mant[FRAC_W+1:2])));
  // R9: sign lands in the top bit
  a_r9_sign: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word[WORD_W-1] == $past(in_sign)));
  // R10: remainder bits pass through
  a_r10_rem: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_rem == $past(in_mant[1:0])));
endmodule

// File: tb/fp64_round_unit_tb.sv
module fp64_round_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_sign;
  logic [11:0] in_exp;
  logic [55:0] in_mant;
  logic [1:0]  in_mode;
  logic        out_valid;
  logic [63:0] out_word;
  logic        out_ovf;
  logic [1:0]  out_rem;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fp64_round_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_mode(in_mode),
    .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf),
    .out_rem(out_rem)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] last_word;
    rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0;
    in_mant = '0; in_mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_word == '0 && out_ovf == 1'b0 && out_rem == 2'b00,
        "R1 reset", {out_valid, out_ovf, out_rem, out_word[59:0]}, 64'd0);
    rst = 1'b0;

    for (int m = 0; m < 4; m++)
      for (int sg = 0; sg < 2; sg++)
        for (int rm = 0; rm < 4; rm++)
          for (int lb = 0; lb < 2; lb++)
            for (int pat = 0; pat < 2; pat++)
              for (int ei = 0; ei < 4; ei++) begin
                logic [51:0] f;
                logic [11:0] e;
                logic        g, s, inc, carry, ovf;
                logic [53:0] sum;
                logic [51:0] ef;
                logic [11:0] e2;
                logic [63:0] expw;
                string       tag;
                f = (pat == 0) ? {51'h7FFFFFFFFFFFF, 1'b0} : 52'h5A5A5A5A5A5A4;
                f[0] = lb[0];
                case (ei)
                  0: e = 12'd1;
                  1: e = 12'd1023;
                  2: e = 12'd2046;
                  default: e = 12'd2047;
                endcase
                g = rm[1]; s = rm[0];
                case (m)
                  0: begin inc = g & (s | lb[0]);      tag = "R4"; end
                  1: begin inc = 1'b0;                 tag = "R3"; end
                  2: begin inc = (g | s) & ~sg[0];     tag = "R5"; end
                  default: begin inc = (g | s) & sg[0]; tag = "R6"; end
                endcase
                sum   = {2'b01, f} + {53'd0, inc};
                carry = sum[53];
                ef    = carry ? sum[52:1] : sum[51:0];
                e2    = e + {11'd0, carry};
                ovf   = (e2 >= 12'd2047);
                expw  = {sg[0], e2[10:0], ef};
                if (carry) tag = {tag, " R7"};

                in_valid = 1'b1; in_sign = sg[0]; in_exp = e;
                in_mant = {2'b01, f, rm[1:0]}; in_mode = m[1:0];
                @(posedge clk);
                @(negedge clk);
                chk(out_valid == 1'b1, "R2 valid", {63'd0, out_valid}, 64'd1);
                chk(out_word == expw, {tag, " R9 word"}, out_word, expw);
                chk(out_ovf == ovf, "R8 overflow", {63'd0, out_ovf}, {63'd0, ovf});
                chk(out_rem == rm[1:0], "R10 remainder", {62'd0, out_rem}, {62'd0, rm[1:0]});
              end

    last_word = out_word;
    in_valid = 1'b0; in_sign = ~in_sign; in_exp = 12'd5;
    in_mant = 56'h00FFFFFFFFFFFF; in_mode = 2'b00;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle valid", {63'd0, out_valid}, 64'd0);
    chk(out_word == last_word, "R2 hold word", out_word, last_word);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule